// File: doc/BRIEF.md
# Reciprocal-Based Integer Divider

This block divides one unsigned 64-bit integer by another. It does not use shift-and-subtract. It estimates the divisor's reciprocal and multiplies that by the dividend. A leading-zero count first brings the divisor into the range [1, 2). Eight bits below its leading one then select a seed from a 256-entry reciprocal table. The seed is built into the block as a constant and always lies at or below the true reciprocal.

Newton-Raphson passes then refine the seed, and all of them run on one shared wide multiplier. The dividend's significant-bit count sets how many passes run, between one and three. The refined reciprocal times the dividend, shifted back by the normalization amount, gives a quotient estimate. That estimate is either exact or one short. One remainder computation and one conditional correction finish the job. The `modulo` input selects whether the quotient or the remainder is returned.

A caller pulses `start` with the operands while the unit is idle. It then waits for the one-cycle `done` pulse, which carries the answer on `result`.

Top module: `recip_divider`

## Requirements
- R1: With `modulo` = 0, `result` on the `done` cycle equals floor(dividend / divisor) for every non-zero divisor.
- R2: With `modulo` = 1, `result` on the `done` cycle equals dividend mod divisor for every non-zero divisor.
- R3: For a non-zero divisor, `done` rises 2k+3 clock edges after the edge that accepts `start`. The pass count k is 1 when the dividend has at most 16 significant bits (a zero dividend counts as 0 bits), 2 when it has at most 32, and 3 otherwise.
- R4: A zero divisor gives `result` = 0 with `done` high after the very edge that accepts `start`, and no refinement passes run.
- R5: `done` is high for exactly one cycle per accepted operation.
- R6: `start` is ignored while an operation is in flight. Operands offered then change neither the answer nor the number of `done` pulses.
- R7: After reset, `done` is 0 and `result` is 0.
- R8: The remainder computed from the quotient estimate lies in [0, 2·divisor), so one conditional correction always gives the exact answer. Worst cases include divisors of 1, near powers of two, and all-ones dividends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation; honoured only while idle |
| modulo | input | 1 | 0 returns the quotient, 1 returns the remainder |
| dividend | input | 64 | Unsigned numerator |
| divisor | input | 64 | Unsigned denominator |
| result | output | 64 | Quotient or remainder, valid while `done` is high |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the following on every cycle:
- `done` never stays high for two cycles.
- A zero divisor finishes on the next edge with a zero result.
- The latched divisor does not move while the unit is busy.
- The pass counter never overruns its goal.
- Before correction, the remainder estimate is always below twice the divisor.

Some behaviours only the bench's scenarios can show:
- Arithmetic correctness over boundary and pseudo-random operands.
- The exact latency chosen by the dividend's significance at the 16/17 and 32/33-bit boundaries.
- Operands offered during a busy period having no effect on the answer.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ERR,
    ST_UPD,
    ST_QEST,
    ST_REM,
    ST_FIX
  } rdiv_state_e;

  // Most passes ever needed: accuracy doubles from seed_prec bits per pass.
  function automatic int pass_max(int width, int seed_prec);
    int g;
    g = 1;
    for (int i = 0; i < 16; i++)
      if ((seed_prec << g) < width) g++;
    return g;
  endfunction

  // Passes needed for a dividend with sig_bits significant bits.
  function automatic int pass_goal(int sig_bits, int seed_prec, int max_pass);
    int g;
    g = 1;
    for (int i = 1; i < max_pass; i++)
      if ((seed_prec << g) < sig_bits) g++;
    return g;
  endfunction

endpackage

// File: rtl/rdiv_lzc.sv
module rdiv_lzc #(
  parameter int W   = 64,
  parameter int LZW = $clog2(W + 1)
) (
  input  logic [W-1:0]   value,
  output logic [LZW-1:0] zeros
);
  int cnt;
  always_comb begin
    cnt = W;
    for (int i = 0; i < W; i++)
      if (value[i]) cnt = W - 1 - i;
    zeros = LZW'(cnt);
  end
endmodule

// File: rtl/rdiv_seed_rom.sv
module rdiv_seed_rom #(
  parameter int IB = 8,
  parameter int SB = 24
) (
  input  logic [IB-1:0] idx,
  output logic [SB-1:0] seed
);
  localparam int ENT = 1 << IB;

  logic [SB-1:0] rom [ENT];

  // Entry i: floor(2^SB / f_hi), f_hi = top of the interval selected by i.
  for (genvar i = 0; i < ENT; i++) begin : g_ent
    localparam logic [63:0] QV = (64'd1 << (SB + IB)) / 64'(ENT + i + 1);
    assign rom[i] = QV[SB-1:0];
  end

  assign seed = rom[idx];
endmodule

// File: rtl/rdiv_fix.sv
module rdiv_fix #(
  parameter int W = 64
) (
  input  logic [W-1:0] est_q,
  input  logic [W-1:0] est_rem,
  input  logic [W-1:0] dvs,
  input  logic         pick_rem,
  output logic [W-1:0] value
);
  logic         short_by_one;
  logic [W-1:0] q_fixed;
  logic [W-1:0] r_fixed;

  always_comb begin
    short_by_one = (est_rem >= dvs);
    q_fixed      = short_by_one ? est_q + W'(1) : est_q;
    r_fixed      = short_by_one ? est_rem - dvs : est_rem;
    value        = pick_rem ? r_fixed : q_fixed;
  end
endmodule

// File: rtl/recip_divider.sv
module recip_divider
  import rdiv_pkg::*;
#(
  parameter int W     = 64,
  parameter int GUARD = 8,
  parameter int IB    = 8,
  parameter int SB    = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         modulo,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] result,
  output logic         done
);
  localparam int XW       = W + GUARD + 1;
  localparam int EW       = 2 * W + GUARD + 1;
  localparam int PW       = 2 * EW;
  localparam int KSH      = 2 * W + GUARD - 1;
  localparam int LZW      = $clog2(W + 1);
  localparam int SHW      = $clog2(KSH + 1);
  localparam int MAX_PASS = pass_max(W, IB);
  localparam int ITW      = $clog2(MAX_PASS + 1);
  localparam logic [EW-1:0] K_ONE = EW'(1) << KSH;

  rdiv_state_e   st;
  logic [W-1:0]  num_q, dvs_q, dnorm_q, qe_q, rem_q;
  logic [XW-1:0] x_q;
  logic [EW-1:0] err_q;
  logic [LZW-1:0] lz_q;
  logic [ITW-1:0] pass_q, goal_q;
  logic           mod_q;

  logic [LZW-1:0] lz_d, lz_n;
  logic [W-1:0]   dn_in;
  logic [SB-1:0]  seed_val;
  logic [XW-1:0]  x_seed;
  logic [ITW-1:0] goal_in;

  logic [EW-1:0] mul_a, mul_b;
  logic [PW-1:0] mul_p;
  logic [EW-1:0] err_nx;
  logic [XW-1:0] upd_nx;
  logic [SHW-1:0] q_shift;
  logic [W-1:0]  qe_nx, rem_nx, fix_val;

  // Named events for the checker
  logic idle_w, fix_w;
  assign idle_w = (st == ST_IDLE);
  assign fix_w  = (st == ST_FIX);

  rdiv_lzc #(.W(W), .LZW(LZW)) u_lz_dvs (.value(divisor),  .zeros(lz_d));
  rdiv_lzc #(.W(W), .LZW(LZW)) u_lz_num (.value(dividend), .zeros(lz_n));

  assign dn_in = divisor << lz_d;

  rdiv_seed_rom #(.IB(IB), .SB(SB)) u_seed (
    .idx  (dn_in[W-2 -: IB]),
    .seed (seed_val)
  );

  assign x_seed  = XW'(seed_val) << (W + GUARD - SB);
  assign goal_in = ITW'(pass_goal(W - int'(lz_n), IB, MAX_PASS));

  // Shared multiplier operand selection
  always_comb begin
    mul_a = '0;
    mul_b = '0;
    case (st)
      ST_ERR:  begin mul_a = EW'(dnorm_q); mul_b = EW'(x_q);  end
      ST_UPD:  begin mul_a = EW'(x_q);     mul_b = err_q;      end
      ST_QEST: begin mul_a = EW'(num_q);   mul_b = EW'(x_q);  end
      ST_REM:  begin mul_a = EW'(qe_q);    mul_b = EW'(dvs_q); end
      default: ;
    endcase
  end

  assign mul_p   = PW'(mul_a) * PW'(mul_b);
  assign err_nx  = EW'(PW'(K_ONE) - mul_p);
  assign upd_nx  = x_q + XW'(mul_p >> KSH);
  assign q_shift = SHW'(KSH) - SHW'(lz_q);
  assign qe_nx   = W'(mul_p >> q_shift);
  assign rem_nx  = num_q - W'(mul_p);

  rdiv_fix #(.W(W)) u_fix (
    .est_q    (qe_q),
    .est_rem  (rem_q),
    .dvs      (dvs_q),
    .pick_rem (mod_q),
    .value    (fix_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      done    <= 1'b0;
      result  <= '0;
      num_q   <= '0;
      dvs_q   <= '0;
      dnorm_q <= '0;
      qe_q    <= '0;
      rem_q   <= '0;
      x_q     <= '0;
      err_q   <= '0;
      lz_q    <= '0;
      pass_q  <= '0;
      goal_q  <= '0;
      mod_q   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            if (divisor == '0) begin
              done   <= 1'b1;
              result <= '0;
            end else begin
              num_q   <= dividend;
              dvs_q   <= divisor;
              dnorm_q <= dn_in;
              x_q     <= x_seed;
              lz_q    <= lz_d;
              goal_q  <= goal_in;
              pass_q  <= '0;
              mod_q   <= modulo;
              st      <= ST_ERR;
            end
          end
        end
        ST_ERR: begin
          err_q <= err_nx;
          st    <= ST_UPD;
        end
        ST_UPD: begin
          x_q    <= upd_nx;
          pass_q <= pass_q + ITW'(1);
          st     <= (pass_q + ITW'(1) == goal_q) ? ST_QEST : ST_ERR;
        end
        ST_QEST: begin
          qe_q <= qe_nx;
          st   <= ST_REM;
        end
        ST_REM: begin
          rem_q <= rem_nx;
          st    <= ST_FIX;
        end
        ST_FIX: begin
          result <= fix_val;
          done   <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/recip_divider_chk.sv
module recip_divider_chk #(
  parameter int W        = 64,
  parameter int ITW      = 2,
  parameter int MAX_PASS = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [W-1:0]   divisor,
  input logic           done,
  input logic [W-1:0]   result,
  input logic           idle,
  input logic           fix_phase,
  input logic [W-1:0]   est_rem,
  input logic [W-1:0]   dvs_q,
  input logic [ITW-1:0] pass_q,
  input logic [ITW-1:0] goal_q
);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start && divisor == '0) |=> (done && result == '0));

  // R6
  hold_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(dvs_q));

  // R8
  single_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fix_phase |-> ({1'b0, est_rem} < {dvs_q, 1'b0}));

  // R3
  pass_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> (goal_q >= ITW'(1) && goal_q <= ITW'(MAX_PASS) && pass_q <= goal_q));

  // R3
  pass_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fix_phase |-> (pass_q == goal_q));
endmodule

bind recip_divider recip_divider_chk #(.W(W), .ITW(ITW), .MAX_PASS(MAX_PASS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .divisor   (divisor),
  .done      (done),
  .result    (result),
  .idle      (idle_w),
  .fix_phase (fix_w),
  .est_rem   (rem_q),
  .dvs_q     (dvs_q),
  .pass_q    (pass_q),
  .goal_q    (goal_q)
);

// File: tb/recip_divider_test.sv
module recip_divider_test;
  localparam int CLK_NS = 10;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        modulo = 1'b0;
  logic [63:0] dividend = '0;
  logic [63:0] divisor = '0;
  logic [63:0] result;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_NS / 2) clk = ~clk;

  recip_divider uut (
    .clk(clk), .rst_n(rst_n), .start(start), .modulo(modulo),
    .dividend(dividend), .divisor(divisor), .result(result), .done(done)
  );

  // Reference model: pass count from dividend significance (R3)
  function automatic int passes(logic [63:0] n);
    int sb;
    sb = 0;
    for (int i = 0; i < 64; i++) if (n[i]) sb = i + 1;
    return (sb <= 16) ? 1 : (sb <= 32) ? 2 : 3;
  endfunction

  bit          busy_m = 1'b0;
  int          cnt_m = 0;
  bit          exp_done = 1'b0;
  logic [63:0] exp_res = '0;
  logic [63:0] pend_res = '0;
  string       pend_tag = "";
  string       exp_tag = "";
  string       cur_tag = "";

  always @(posedge clk) begin
    if (!rst_n) begin
      busy_m   = 1'b0;
      exp_done = 1'b0;
      cnt_m    = 0;
    end else begin
      exp_done = 1'b0;
      if (busy_m) begin
        cnt_m--;
        if (cnt_m == 0) begin
          busy_m   = 1'b0;
          exp_done = 1'b1;
          exp_res  = pend_res;
          exp_tag  = pend_tag;
        end
      end else if (start) begin
        if (divisor == 0) begin
          exp_done = 1'b1;
          exp_res  = '0;
          exp_tag  = "R4";
        end else begin
          busy_m   = 1'b1;
          cnt_m    = 2 * passes(dividend) + 3;
          pend_res = modulo ? dividend % divisor : dividend / divisor;
          pend_tag = cur_tag;
        end
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (done !== exp_done) begin
        errors++;
        $display("FAIL done timing (R3, R5) [%s]: actual %b expected %b at %0t",
                 cur_tag, done, exp_done, $time);
      end
      if (exp_done) begin
        checks++;
        if (result !== exp_res) begin
          errors++;
          $display("FAIL %s result: actual %h expected %h", exp_tag, result, exp_res);
        end
      end
    end
  end

  task automatic op(input logic [63:0] n, input logic [63:0] d, input bit m, input string tag);
    @(negedge clk);
    cur_tag  = tag;
    dividend = n;
    divisor  = d;
    modulo   = m;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy_m) @(negedge clk);
    @(negedge clk);
  endtask

  logic [63:0] rs = 64'h9E37_79B9_7F4A_7C15;
  function automatic logic [63:0] nxt(logic [63:0] s);
    logic [63:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 7);
    t = t ^ (t << 17);
    return t;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    checks++;
    if (done !== 1'b0 || result !== 64'd0) begin
      errors++;
      $display("FAIL R7 reset: actual done=%b result=%h expected done=0 result=0", done, result);
    end
    rst_n = 1'b1;
    @(negedge clk);

    op(64'd100, 64'd7, 1'b0, "R1");
    op(ONES, 64'd1, 1'b0, "R1");
    op(ONES, ONES, 1'b0, "R1");
    op(64'd5, 64'd10, 1'b0, "R1");
    op(64'd0, 64'd3, 1'b0, "R1");
    op(ONES, 64'd3, 1'b0, "R1");

    op(64'd100, 64'd7, 1'b1, "R2");
    op(ONES, 64'h1_0000_0001, 1'b1, "R2");
    op(64'd7, 64'd7, 1'b1, "R2");
    op(64'h8000_0000_0000_0000, 64'd3, 1'b1, "R2");

    op(64'h0000_FFFF, 64'd3, 1'b0, "R3");
    op(64'h0001_0000, 64'd3, 1'b0, "R3");
    op(64'hFFFF_FFFF, 64'd3, 1'b1, "R3");
    op(64'h1_0000_0000, 64'd3, 1'b0, "R3");

    op(64'd12345, 64'd0, 1'b0, "R4");
    op(64'd12345, 64'd0, 1'b1, "R4");

    op(ONES, 64'h8000_0000_0000_0001, 1'b0, "R8");
    op(ONES, 64'hFFFF_FFFF, 1'b0, "R8");
    op(ONES - 1, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, "R8");
    op(ONES, 64'd2, 1'b0, "R8");
    op(ONES, 64'h0100_0000, 1'b1, "R8");
    op(ONES, 64'h01FF_FFFF, 1'b0, "R8");

    // R6: second start during a busy period is ignored
    @(negedge clk);
    cur_tag = "R6"; dividend = ONES; divisor = 64'd9; modulo = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    dividend = 64'd50; divisor = 64'd0; modulo = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy_m) @(negedge clk);
    @(negedge clk);
    op(64'd1000, 64'd33, 1'b1, "R6");

    for (int k = 0; k < 300; k++) begin
      logic [63:0] n, d;
      bit m;
      rs = nxt(rs); n = rs >> rs[5:0];
      rs = nxt(rs); d = rs >> rs[5:0];
      rs = nxt(rs); m = rs[7];
      op(n, d, m, m ? "R2" : "R1");
    end

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule